// File: doc/BRIEF.md
# Clock Source Mode Controller

This block decides which of three sources drives the system clock: the output of the frequency-locked or phase-locked loop, an external reference, or an internal reference. Software programs it through three control registers and reads one status register over a simple 8-bit bus. A state machine tracks the operating mode. The mode is "engaged" when the loop drives the output, "bypass" when a reference drives it, "low-power bypass" when a reference drives it and the loop is switched off, and "switching" while a change of source settles. The status fields follow the control fields only after a fixed settling delay, which models the handshake of a glitch-free clock switch.

The block also computes the effective reference divider. The same divider code means a different ratio depending on which loop is chosen: code 3 divides by 8 for the PLL, and with the extra divide-by-32 bit it divides by 256 for the FLL. An 8 MHz crystal therefore gives a 31.25 kHz FLL reference, which is inside the 31.25 to 39.06 kHz window the FLL accepts. The divider must be set before the PLL-select bit is cleared. Lock acquisition is modelled by a counter.

The state machine has four states. ST_ENGAGED means the loop is the source. ST_BYPASS means a reference is the source and the loop is running. ST_LP_BYP means a reference is the source and the loop is off. ST_SWITCH means a source change is settling. Its transitions are:
- engage-request, bypass-request and cross-request: a steady state moves to ST_SWITCH when the requested source differs from the active one.
- switch-done: ST_SWITCH moves to the steady state for the new source after the settle count.
- lp-enter: ST_BYPASS moves to ST_LP_BYP when the low-power bit is set.
- lp-leave: ST_LP_BYP moves back to ST_BYPASS when the low-power bit is cleared.
- engage-hold: a request for the loop while the low-power bit is set keeps the current state until the bit is cleared.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00. The outputs are clk_src=0, mode=0, loop_en=1, pll_active=0, lock=0, ref_div=1 and vco_div=0.
- R2: Register map by address:
  - Address 0 has select in bits 7:6 and divider code in bits 5:3; it reads back with mask 0xF8.
  - Address 1 has the low-power bit in bit 3; it reads back with mask 0x08.
  - Address 2 has PLL select in bit 6, the divide-by-32 bit in bit 4 and the VCO divider in bits 3:0; it reads back with mask 0x5F.
  - Address 3 is the read-only status register, and writes to it are ignored.
- R3: Select codes are 0 for the loop, 1 for the internal reference and 2 for the external reference. Code 3 leaves the active source unchanged. clk_src and status bits 3:2 show the active source, using the same codes.
- R4: After a write that changes the source, clk_src and status bits 3:2 keep the old value for SETTLE_CYCLES edges after the write edge. They take the new value at the edge after that, when mode leaves switching (mode=3). The new mode is 0 for the loop and 1 for a reference.
- R5: pll_active and status bit 5 take the new PLL-select value SETTLE_CYCLES+1 edges after the write edge.
- R6: ref_div equals 2^code when PLL select is 1 or the divide-by-32 bit is 0. It equals 32*2^code when PLL select is 0 and the divide-by-32 bit is 1. It follows the write edge directly.
- R7: vco_div shows the VCO divider field only while PLL select is 1, and 0 otherwise. Writing that field while PLL select is 0 does not disturb lock.
- R8: lock (status bit 6) sets LOCK_CYCLES edges after reset release. It clears one edge after a write that changes PLL select, the divide-by-32 bit, the divider code, or the VCO divider while the PLL is selected. It sets again LOCK_CYCLES+1 edges after that write.
- R9: Setting the low-power bit while a reference is the active source drops loop_en at once. At the next edge mode becomes 2 and lock clears. Clearing the bit raises loop_en at once and returns mode to 1 at the next edge. Lock then sets LOCK_CYCLES edges after the clearing write.
- R10: A request for the loop while the low-power bit is set and a reference is active changes nothing until the bit is cleared. The switch then completes SETTLE_CYCLES+1 edges after the clearing write.
- R11: The low-power bit has no effect while the loop is engaged: loop_en stays 1, mode stays 0 and lock holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| clk_src | output | 2 | Active source, drives the source mux |
| mode | output | 2 | 0 engaged, 1 bypass, 2 low-power bypass, 3 switching |
| loop_en | output | 1 | Loop enable |
| pll_active | output | 1 | PLL is the active loop |
| lock | output | 1 | Loop lock flag |
| ref_div | output | 13 | Effective reference divide ratio |
| vco_div | output | 4 | Effective VCO divider, 0 when the FLL is selected |

## Verification
ref_div, vco_div, loop_en and the register read-back follow the write edge directly, so the bench checks them on the falling edge right after the write. The source and PLL status are checked on the falling edge SETTLE_CYCLES edges after the write, where they must still hold the old value, and again one edge later, where they must hold the new one. The same two-sided checks apply to the low-power mode, one edge after the write, and to lock: one edge after a divider change, then one edge short of the lock count, then at the lock count. Every source/code pair and every divider combination is swept, and the expected values are computed by arithmetic in the bench.

// File: rtl/csm_pkg.sv
package csm_pkg;

    localparam int SEL_W     = 2;
    localparam int RDIV_W    = 3;
    localparam int VDIV_W    = 4;
    localparam int FLL_EXTRA = 5;
    localparam int DIV_W     = (1 << RDIV_W) + FLL_EXTRA;
    localparam int SHIFT_W   = RDIV_W + 1;

    localparam logic [1:0] ADR_CTRL1 = 2'd0;
    localparam logic [1:0] ADR_CTRL2 = 2'd1;
    localparam logic [1:0] ADR_CTRL3 = 2'd2;
    localparam logic [1:0] ADR_STAT  = 2'd3;

    typedef enum logic [SEL_W-1:0] {
        SRC_LOOP = 2'd0,
        SRC_INT  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_ENGAGED = 2'd0,
        ST_BYPASS  = 2'd1,
        ST_LP_BYP  = 2'd2,
        ST_SWITCH  = 2'd3
    } mode_e;

endpackage

// File: rtl/csm_regs.sv
module csm_regs
    import csm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic [SEL_W-1:0]  st_src,
    input  logic              st_pll,
    input  logic              st_lock,
    output logic [SEL_W-1:0]  sel_req,
    output logic [RDIV_W-1:0] rdiv,
    output logic              lp,
    output logic              pll_sel,
    output logic              div32,
    output logic [VDIV_W-1:0] vdiv,
    output logic [7:0]        reg_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_req <= '0;
            rdiv    <= '0;
            lp      <= 1'b0;
            pll_sel <= 1'b0;
            div32   <= 1'b0;
            vdiv    <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                ADR_CTRL1: begin
                    sel_req <= reg_wdata[7:6];
                    rdiv    <= reg_wdata[5:3];
                end
                ADR_CTRL2: lp <= reg_wdata[3];
                ADR_CTRL3: begin
                    pll_sel <= reg_wdata[6];
                    div32   <= reg_wdata[4];
                    vdiv    <= reg_wdata[3:0];
                end
                ADR_STAT: ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADR_CTRL1: reg_rdata = {sel_req, rdiv, 3'b000};
            ADR_CTRL2: reg_rdata = {4'b0000, lp, 3'b000};
            ADR_CTRL3: reg_rdata = {1'b0, pll_sel, 1'b0, div32, vdiv};
            ADR_STAT:  reg_rdata = {1'b0, st_lock, st_pll, 1'b0, st_src, 2'b00};
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[2:0], reg_wdata[7:6] & {2{reg_addr == ADR_CTRL2}}};

endmodule

// File: rtl/csm_mode_fsm.sv
module csm_mode_fsm
    import csm_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_req,
    input  logic             lp,
    output logic [SEL_W-1:0] src,
    output logic [1:0]       mode
);

    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    mode_e            state_q, state_d;
    src_e             src_q, tgt_q, want;
    logic [CNT_W-1:0] cnt_q;
    logic             switch_req;

    function automatic mode_e rest_mode(input src_e s, input logic low_pwr);
        if (s == SRC_LOOP)  return ST_ENGAGED;
        else if (low_pwr)   return ST_LP_BYP;
        else                return ST_BYPASS;
    endfunction

    // select code 3 means "keep what is active"
    always_comb begin
        want       = (sel_req == SRC_RSVD) ? src_q : src_e'(sel_req);
        switch_req = (want != src_q) && !(want == SRC_LOOP && lp);
    end

    always_comb begin
        unique case (state_q)
            ST_ENGAGED,
            ST_BYPASS,
            ST_LP_BYP: state_d = switch_req ? ST_SWITCH : rest_mode(src_q, lp);
            ST_SWITCH: state_d = (cnt_q == CNT_LAST) ? rest_mode(tgt_q, lp) : ST_SWITCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ENGAGED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= SRC_LOOP;
            tgt_q <= SRC_LOOP;
            cnt_q <= '0;
        end else if (state_q != ST_SWITCH && state_d == ST_SWITCH) begin
            tgt_q <= want;
            cnt_q <= '0;
        end else if (state_q == ST_SWITCH) begin
            if (cnt_q == CNT_LAST) src_q <= tgt_q;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end

    assign src  = src_q;
    assign mode = state_q;

endmodule

// File: rtl/csm_loop_track.sv
module csm_loop_track
    import csm_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4,
    parameter int LOCK_CYCLES   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_sel,
    input  logic              div32,
    input  logic [RDIV_W-1:0] rdiv,
    input  logic [VDIV_W-1:0] vdiv,
    input  logic              loop_en,
    output logic              pll_active,
    output logic              lock,
    output logic [DIV_W-1:0]  ref_div,
    output logic [VDIV_W-1:0] vco_div
);

    localparam int PC_W = $clog2(SETTLE_CYCLES + 1);
    localparam int LC_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam int CFG_W = 2 + RDIV_W + VDIV_W;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(SETTLE_CYCLES);
    localparam logic [LC_W-1:0] LC_LAST = LC_W'(LOCK_CYCLES - 1);

    logic [PC_W-1:0]    pcnt_q;
    logic [LC_W-1:0]    lcnt_q;
    logic [CFG_W-1:0]   cfg, cfg_q;
    logic [SHIFT_W-1:0] shift;

    // the VCO divider only matters when the PLL is the chosen loop
    assign vco_div = pll_sel ? vdiv : '0;
    assign cfg     = {pll_sel, div32, rdiv, vco_div};

    // the same divider code gets the extra divide-by-32 only for the FLL
    assign shift   = {1'b0, rdiv} + ((!pll_sel && div32) ? SHIFT_W'(FLL_EXTRA) : '0);
    assign ref_div = DIV_W'(1) << shift;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_active <= 1'b0;
            pcnt_q     <= '0;
        end else if (pll_sel != pll_active) begin
            if (pcnt_q == PC_LAST) begin
                pll_active <= pll_sel;
                pcnt_q     <= '0;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end else begin
            pcnt_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            lcnt_q <= '0;
            lock   <= 1'b0;
        end else begin
            cfg_q <= cfg;
            if (!loop_en || cfg != cfg_q) begin
                lock   <= 1'b0;
                lcnt_q <= '0;
            end else if (!lock) begin
                if (lcnt_q == LC_LAST) lock <= 1'b1;
                else                   lcnt_q <= lcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import csm_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4,
    parameter int LOCK_CYCLES   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [SEL_W-1:0] clk_src,
    output logic [1:0]       mode,
    output logic             loop_en,
    output logic             pll_active,
    output logic             lock,
    output logic [DIV_W-1:0] ref_div,
    output logic [3:0]       vco_div
);

    logic [SEL_W-1:0]  sel_req;
    logic [RDIV_W-1:0] rdiv;
    logic              lp;
    logic              pll_sel;
    logic              div32;
    logic [VDIV_W-1:0] vdiv;

    csm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .st_src    (clk_src),
        .st_pll    (pll_active),
        .st_lock   (lock),
        .sel_req   (sel_req),
        .rdiv      (rdiv),
        .lp        (lp),
        .pll_sel   (pll_sel),
        .div32     (div32),
        .vdiv      (vdiv),
        .reg_rdata (reg_rdata)
    );

    csm_mode_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_req (sel_req),
        .lp      (lp),
        .src     (clk_src),
        .mode    (mode)
    );

    // low power only stops the loop while a reference feeds the output
    assign loop_en = !(lp && clk_src != SRC_LOOP);

    csm_loop_track #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .LOCK_CYCLES   (LOCK_CYCLES)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .pll_sel    (pll_sel),
        .div32      (div32),
        .rdiv       (rdiv),
        .vdiv       (vdiv),
        .loop_en    (loop_en),
        .pll_active (pll_active),
        .lock       (lock),
        .ref_div    (ref_div),
        .vco_div    (vco_div)
    );

endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] clk_src,
    input logic [1:0] mode,
    input logic       loop_en,
    input logic       lock,
    input logic       pll_active,
    input logic       pll_sel
);

    // R3
    src_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_src != 2'b11);

    // R4
    src_moves_from_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src != $past(clk_src)) |-> ($past(mode) == 2'd3));

    // R5
    pll_follows_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_active != $past(pll_active)) |-> ($past(pll_sel) != $past(pll_active)));

    // R8
    lock_needs_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(loop_en));

    // R9
    lock_drops_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loop_en) |=> !lock);

    // R10
    engaged_means_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (clk_src == 2'd0));

endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_src    (clk_src),
    .mode       (mode),
    .loop_en    (loop_en),
    .lock       (lock),
    .pll_active (pll_active),
    .pll_sel    (pll_sel)
);

// File: tb/test_clk_mode_ctrl.sv
`timescale 1ns/1ps
module test_clk_mode_ctrl;

    localparam int S = 4;
    localparam int L = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [1:0]  clk_src;
    logic [1:0]  mode;
    logic        loop_en;
    logic        pll_active;
    logic        lock;
    logic [12:0] ref_div;
    logic [3:0]  vco_div;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clk_mode_ctrl #(.SETTLE_CYCLES(S), .LOCK_CYCLES(L)) i_clk_mode_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .clk_src    (clk_src),
        .mode       (mode),
        .loop_en    (loop_en),
        .pll_active (pll_active),
        .lock       (lock),
        .ref_div    (ref_div),
        .vco_div    (vco_div)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic src_status(input string tag, input int exp);
        logic [7:0] st;
        rd(2'd3, st);
        chk({tag, " clk_src"}, int'(clk_src), exp);
        chk({tag, " status src"}, int'(st[3:2]), exp);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] st0;
        tick(3);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset reg", int'(v), 0);
        end
        chk("R1 clk_src", int'(clk_src), 0);
        chk("R1 mode", int'(mode), 0);
        chk("R1 loop_en", int'(loop_en), 1);
        chk("R1 pll_active", int'(pll_active), 0);
        chk("R1 lock", int'(lock), 0);
        chk("R1 ref_div", int'(ref_div), 1);
        chk("R1 vco_div", int'(vco_div), 0);
        rst_n = 1'b1;
        // R8 lock after reset release
        tick(L - 1);
        chk("R8 lock before count", int'(lock), 0);
        tick(1);
        chk("R8 lock at count", int'(lock), 1);

        // R2 status writes ignored
        rd(2'd3, st0);
        wr(2'd3, 8'hFF);
        tick(2);
        rd(2'd3, v);
        chk("R2 status write ignored", int'(v), int'(st0));

        // R2 read-back sweep
        for (int a = 0; a < 3; a++) begin
            for (int d = 0; d < 256; d++) begin
                wr(2'(a), 8'(d));
                rd(2'(a), v);
                chk("R2 readback", int'(v),
                    d & ((a == 0) ? 8'hF8 : (a == 1) ? 8'h08 : 8'h5F));
            end
        end
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
        tick(60);

        // R6 / R7 divider sweep
        for (int p = 0; p < 2; p++)
            for (int d = 0; d < 2; d++)
                for (int r = 0; r < 8; r++) begin
                    wr(2'd2, 8'((p << 6) | (d << 4) | 9));
                    wr(2'd0, 8'(r << 3));
                    chk("R6 ref_div", int'(ref_div),
                        (p == 0 && d == 1) ? (32 << r) : (1 << r));
                    chk("R7 vco_div", int'(vco_div), p ? 9 : 0);
                end
        wr(2'd2, 8'h00); wr(2'd0, 8'h00);
        tick(60);

        // R5 PLL status timing
        wr(2'd2, 8'h40);
        tick(S);
        rd(2'd3, v);
        chk("R5 pll_active old", int'(pll_active), 0);
        chk("R5 status bit5 old", int'(v[5]), 0);
        tick(1);
        rd(2'd3, v);
        chk("R5 pll_active new", int'(pll_active), 1);
        chk("R5 status bit5 new", int'(v[5]), 1);
        wr(2'd2, 8'h00);
        tick(S);
        chk("R5 pll_active back old", int'(pll_active), 1);
        tick(1);
        chk("R5 pll_active back new", int'(pll_active), 0);
        tick(60);

        // R8 lock on divider change
        chk("R8 locked before", int'(lock), 1);
        wr(2'd0, 8'h18);
        chk("R8 lock after write edge", int'(lock), 1);
        tick(1);
        chk("R8 lock cleared", int'(lock), 0);
        tick(L - 1);
        chk("R8 lock not yet", int'(lock), 0);
        tick(1);
        rd(2'd3, v);
        chk("R8 lock relock", int'(lock), 1);
        chk("R8 status bit6", int'(v[6]), 1);

        // R7 VCO divider ignored under FLL
        wr(2'd2, 8'h05);
        tick(3);
        chk("R7 lock kept", int'(lock), 1);
        chk("R7 vco_div zero", int'(vco_div), 0);

        // R3 / R4 every source and code
        for (int f = 0; f < 3; f++)
            for (int c = 0; c < 4; c++) begin
                int e;
                e = (c == 3) ? f : c;
                wr(2'd0, 8'((f << 6) | 8'h18));
                tick(S + 3);
                src_status("R3 start", f);
                wr(2'd0, 8'((c << 6) | 8'h18));
                tick(S);
                src_status("R4 old", f);
                if (e != f) chk("R4 switching", int'(mode), 3);
                tick(1);
                src_status("R3 new", e);
                chk("R4 mode", int'(mode), (e == 0) ? 0 : 1);
            end

        // R9 low power in external bypass
        wr(2'd0, 8'h98);
        tick(S + L + 4);
        chk("R9 bypass locked", int'(lock), 1);
        wr(2'd1, 8'h08);
        chk("R9 loop_en off", int'(loop_en), 0);
        chk("R9 mode before", int'(mode), 1);
        tick(1);
        chk("R9 mode lp", int'(mode), 2);
        chk("R9 lock off", int'(lock), 0);
        tick(4);
        wr(2'd1, 8'h00);
        chk("R9 loop_en on", int'(loop_en), 1);
        tick(1);
        chk("R9 mode back", int'(mode), 1);
        tick(L - 2);
        chk("R9 lock not yet", int'(lock), 0);
        tick(1);
        chk("R9 lock again", int'(lock), 1);

        // R10 engage held while low power
        wr(2'd1, 8'h08);
        tick(2);
        wr(2'd0, 8'h18);
        tick(S + 3);
        chk("R10 held src", int'(clk_src), 2);
        chk("R10 held mode", int'(mode), 2);
        wr(2'd1, 8'h00);
        tick(S);
        chk("R10 still ext", int'(clk_src), 2);
        tick(1);
        chk("R10 engaged src", int'(clk_src), 0);
        chk("R10 engaged mode", int'(mode), 0);

        // R11 low power ignored while engaged
        tick(L + 2);
        wr(2'd1, 8'h08);
        chk("R11 loop_en", int'(loop_en), 1);
        tick(5);
        chk("R11 mode", int'(mode), 0);
        chk("R11 lock", int'(lock), 1);
        chk("R11 loop_en later", int'(loop_en), 1);
        wr(2'd1, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule